// File: doc/BRIEF.md
# Stack frame save/restore sequencer

This block carries out a compressed-code frame SAVE or RESTORE once the instruction's control fields have been decoded. A one-cycle start pulse hands it the direction bit, the return-address, s0 and s1 flags, the extra saved register count, the 4-bit argument code and the frame size nibbles, along with the current stack pointer. The block then walks a fixed register ordering, one word access at a time, over a valid/ready memory port. On SAVE it reads a register-file port and stores the words. On RESTORE it loads words and writes them back into the register file, sign-extended.

The argument code carries two counts. One is the number of incoming argument registers. SAVE stores these above the unmodified stack pointer. The other is the number of static registers, which are saved below the pointer after the callee-saved group. Every access below the pointer uses a pre-decremented address. When the walk ends, the block writes the stack pointer once, with the frame size subtracted on SAVE or added on RESTORE. A done pulse follows in the next cycle. An argument code of 15 in the extended form is reserved: the block reports an error and touches neither memory nor the stack pointer.

Top module: `stack_frame_seq`

## Requirements
- R1: The incoming argument count is taken from the argument code: 0, 1, 2, 3 and 11 give 0; 4 to 7 give 1; 8, 9 and 10 give 2; 12 and 13 give 3; 14 gives 4.
- R2: The static register count is taken from the argument code: 0, 4, 8, 12 and 14 give 0; 1, 5, 9 and 13 give 1; 2, 6 and 10 give 2; 3 and 7 give 3; 11 gives 4.
- R3: On SAVE only, the argument registers are stored first. Register 4+k is written to address SP+4k, for k from 0 up to the argument count minus one, in ascending k. Each such access has mem_we_o=1, and mem_wdata_o equals the register-file read data for rf_raddr_o.
- R4: Next comes a pre-decrement walk. Each access uses the previous address minus 4, and the first access uses the start pointer minus 4. The order is: register 31 if the return-address flag is set; then the last N of the list 30, 23, 22, 21, 20, 19, 18, where N is the extra count; then 17 if s1 is set; then 16 if s0 is set; then registers 7, 6, 5, 4, cut to the static count.
- R5: In the extended form, the frame size is {frame_hi_i, frame_lo_i} times 8 bytes. In the short form it is frame_lo_i times 8 bytes, except that frame_lo_i=0 gives 128 bytes.
- R6: In the short form (ext_i=0), xs_cnt_i and arg_code_i have no effect. They are treated as 0, so no argument or static register is accessed.
- R7: On RESTORE, no argument registers are accessed. The walk of R4 starts from SP plus the frame size. Each access is a read, and the loaded word is written sign-extended to rf_wdata_o, with rf_we_o=1 and rf_waddr_o set to the register, in the cycle the read is accepted. SP is finally written to SP plus the frame size.
- R8: On SAVE, SP is finally written to SP minus the frame size, through a single sp_we_o cycle.
- R9: While mem_valid_o is high and mem_ready_i is low, the address and direction hold. One access completes per accepted cycle.
- R10: done_o is high for exactly one cycle, the cycle after the sp_we_o cycle.
- R11: In the extended form, an argument code of 15 raises err_o for one cycle after start. It gives no memory access, no SP write and no done.
- R12: A start_i pulse, and any change of the command inputs or sp_i, has no effect while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a command (taken only when idle) |
| save_i | input | 1 | 1 = SAVE, 0 = RESTORE |
| ext_i | input | 1 | 1 = extended form fields valid |
| ra_i | input | 1 | Include register 31 |
| s0_i | input | 1 | Include register 16 |
| s1_i | input | 1 | Include register 17 |
| xs_cnt_i | input | 3 | Extra saved register count (extended form) |
| arg_code_i | input | 4 | Argument/static code (extended form) |
| frame_hi_i | input | 4 | Frame size high nibble (extended form) |
| frame_lo_i | input | 4 | Frame size low nibble |
| sp_i | input | AW | Current stack pointer |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_wdata_o | output | AW | New stack pointer |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | 1 = store, 0 = load |
| mem_addr_o | output | AW | Word address (byte units) |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with mem_ready_i |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data (low word) |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | XLEN | Register-file write data, sign-extended |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Reserved-encoding pulse |

## Verification
The bench builds the block with XLEN=64 and AW=32. A 64-bit write port makes the sign extension of each restored word visible in its upper half, and the bench's load data has bit 31 set for roughly half the addresses. A 32-bit pointer lets random stack pointers near zero exercise address wrap in both walk directions. Random ready stalls, junk commands driven during busy, and every argument code in both forms cover the count tables, the ordering, and the reserved case.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int WORD_W  = 32;
  localparam int NREG_W  = 5;
  localparam int NSLOT   = 14;
  localparam int FRAME_W = 11;
  localparam int CNT_W   = $clog2(NSLOT + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARG,
    ST_DOWN,
    ST_SPUPD,
    ST_DONE,
    ST_ERR
  } sfs_state_e;

  typedef struct packed {
    logic               save;
    logic               ra;
    logic               s0;
    logic               s1;
    logic [2:0]         xs;
    logic [2:0]         nargs;
    logic [2:0]         nstat;
    logic [FRAME_W-1:0] frame;
  } sfs_cmd_t;

  // candidate order of the pre-decrement walk
  function automatic logic [NREG_W-1:0] slot_cand(input int i);
    case (i)
      0:       slot_cand = 5'd31;
      1:       slot_cand = 5'd30;
      2:       slot_cand = 5'd23;
      3:       slot_cand = 5'd22;
      4:       slot_cand = 5'd21;
      5:       slot_cand = 5'd20;
      6:       slot_cand = 5'd19;
      7:       slot_cand = 5'd18;
      8:       slot_cand = 5'd17;
      9:       slot_cand = 5'd16;
      10:      slot_cand = 5'd7;
      11:      slot_cand = 5'd6;
      12:      slot_cand = 5'd5;
      default: slot_cand = 5'd4;
    endcase
  endfunction
endpackage

// File: rtl/sfs_arg_decode.sv
module sfs_arg_decode (
  input  logic [3:0] code_i,
  output logic [2:0] nargs_o,
  output logic [2:0] nstat_o,
  output logic       rsvd_o
);
  always_comb begin
    rsvd_o = 1'b0;
    unique case (code_i)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd11: nargs_o = 3'd0;
      4'd4, 4'd5, 4'd6, 4'd7:        nargs_o = 3'd1;
      4'd8, 4'd9, 4'd10:             nargs_o = 3'd2;
      4'd12, 4'd13:                  nargs_o = 3'd3;
      4'd14:                         nargs_o = 3'd4;
      default: begin
        nargs_o = 3'd0;
        rsvd_o  = 1'b1;
      end
    endcase
    unique case (code_i)
      4'd1, 4'd5, 4'd9, 4'd13: nstat_o = 3'd1;
      4'd2, 4'd6, 4'd10:       nstat_o = 3'd2;
      4'd3, 4'd7:              nstat_o = 3'd3;
      4'd11:                   nstat_o = 3'd4;
      default:                 nstat_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/sfs_frame_size.sv
module sfs_frame_size
  import sfs_pkg::*;
(
  input  logic               ext_i,
  input  logic [3:0]         hi_i,
  input  logic [3:0]         lo_i,
  output logic [FRAME_W-1:0] frame_o
);
  always_comb begin
    if (ext_i)              frame_o = {hi_i, lo_i, 3'b000};
    else if (lo_i == 4'd0)  frame_o = FRAME_W'(128);
    else                    frame_o = {4'd0, lo_i, 3'b000};
  end
endmodule

// File: rtl/sfs_slot_list.sv
module sfs_slot_list
  import sfs_pkg::*;
(
  input  logic                         ra_i,
  input  logic                         s0_i,
  input  logic                         s1_i,
  input  logic [2:0]                   xs_i,
  input  logic [2:0]                   nstat_i,
  output logic [NSLOT-1:0][NREG_W-1:0] slot_reg_o,
  output logic [CNT_W-1:0]             n_down_o
);
  logic [NSLOT-1:0] en;

  for (genvar i = 0; i < NSLOT; i++) begin : g_en
    if (i == 0) begin : g_ra
      assign en[i] = ra_i;
    end else if (i <= 7) begin : g_xs
      // count N keeps the tail of the extra list
      assign en[i] = (4'(i) >= (4'd8 - {1'b0, xs_i}));
    end else if (i == 8) begin : g_s1
      assign en[i] = s1_i;
    end else if (i == 9) begin : g_s0
      assign en[i] = s0_i;
    end else begin : g_st
      assign en[i] = (3'(i - 10) < nstat_i);
    end
  end

  always_comb begin
    logic [CNT_W-1:0] cnt;
    cnt        = '0;
    slot_reg_o = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (en[i]) begin
        slot_reg_o[cnt] = slot_cand(i);
        cnt             = cnt + CNT_W'(1);
      end
    end
    n_down_o = cnt;
  end
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         rsvd_i,
  input  sfs_cmd_t                     cmd_d_i,
  input  logic [AW-1:0]                sp_i,
  input  logic [NSLOT-1:0][NREG_W-1:0] slot_reg_i,
  input  logic [CNT_W-1:0]             n_down_i,
  input  logic                         mem_ready_i,
  output sfs_cmd_t                     cmd_q_o,
  output logic                         mem_valid_o,
  output logic                         mem_we_o,
  output logic [AW-1:0]                mem_addr_o,
  output logic [NREG_W-1:0]            reg_sel_o,
  output logic                         rf_we_o,
  output logic                         sp_we_o,
  output logic [AW-1:0]                sp_wdata_o,
  output logic                         done_o,
  output logic                         err_o
);
  localparam logic [AW-1:0] WSTEP = AW'(4);

  sfs_state_e       state_q;
  sfs_cmd_t         cmd_q;
  logic [AW-1:0]    sp_q, ptr_q;
  logic [CNT_W-1:0] idx_q;
  logic [AW-1:0]    fext_q, fext_d;
  logic             walk_end;

  assign fext_q   = AW'(cmd_q.frame);
  assign fext_d   = AW'(cmd_d_i.frame);
  assign walk_end = (idx_q == n_down_i);
  assign cmd_q_o  = cmd_q;

  always_comb begin
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_q - WSTEP;
    reg_sel_o   = '0;
    rf_we_o     = 1'b0;
    sp_we_o     = 1'b0;
    done_o      = 1'b0;
    err_o       = 1'b0;
    sp_wdata_o  = cmd_q.save ? (sp_q - fext_q) : (sp_q + fext_q);
    unique case (state_q)
      ST_ARG: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_q + AW'({idx_q, 2'b00});
        reg_sel_o   = NREG_W'(4) + NREG_W'(idx_q);
      end
      ST_DOWN: begin
        if (!walk_end) begin
          mem_valid_o = 1'b1;
          mem_we_o    = cmd_q.save;
          reg_sel_o   = slot_reg_i[idx_q];
          rf_we_o     = !cmd_q.save && mem_ready_i;
        end
      end
      ST_SPUPD: sp_we_o = 1'b1;
      ST_DONE:  done_o  = 1'b1;
      ST_ERR:   err_o   = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      sp_q    <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cmd_q <= cmd_d_i;
            sp_q  <= sp_i;
            ptr_q <= cmd_d_i.save ? sp_i : (sp_i + fext_d);
            idx_q <= '0;
            if (rsvd_i)                                  state_q <= ST_ERR;
            else if (cmd_d_i.save && cmd_d_i.nargs != 0) state_q <= ST_ARG;
            else                                         state_q <= ST_DOWN;
          end
        end
        ST_ARG: begin
          if (mem_ready_i) begin
            if (idx_q == CNT_W'(cmd_q.nargs) - CNT_W'(1)) begin
              idx_q   <= '0;
              state_q <= ST_DOWN;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
            end
          end
        end
        ST_DOWN: begin
          if (walk_end) begin
            state_q <= ST_SPUPD;
          end else if (mem_ready_i) begin
            ptr_q <= ptr_q - WSTEP;
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        ST_SPUPD: state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import sfs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              save_i,
  input  logic              ext_i,
  input  logic              ra_i,
  input  logic              s0_i,
  input  logic              s1_i,
  input  logic [2:0]        xs_cnt_i,
  input  logic [3:0]        arg_code_i,
  input  logic [3:0]        frame_hi_i,
  input  logic [3:0]        frame_lo_i,
  input  logic [AW-1:0]     sp_i,
  output logic              sp_we_o,
  output logic [AW-1:0]     sp_wdata_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [NREG_W-1:0] rf_raddr_o,
  input  logic [WORD_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [NREG_W-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              done_o,
  output logic              err_o
);
  logic [3:0]                   code_eff;
  logic [2:0]                   nargs, nstat;
  logic                         rsvd;
  logic [FRAME_W-1:0]           frame;
  sfs_cmd_t                     cmd_d, cmd_q;
  logic [NSLOT-1:0][NREG_W-1:0] slot_reg;
  logic [CNT_W-1:0]             n_down;
  logic [NREG_W-1:0]            reg_sel;

  // short form: extension fields read as zero
  assign code_eff = ext_i ? arg_code_i : 4'd0;

  sfs_arg_decode i_arg_decode (
    .code_i  (code_eff),
    .nargs_o (nargs),
    .nstat_o (nstat),
    .rsvd_o  (rsvd)
  );

  sfs_frame_size i_frame_size (
    .ext_i   (ext_i),
    .hi_i    (frame_hi_i),
    .lo_i    (frame_lo_i),
    .frame_o (frame)
  );

  always_comb begin
    cmd_d.save  = save_i;
    cmd_d.ra    = ra_i;
    cmd_d.s0    = s0_i;
    cmd_d.s1    = s1_i;
    cmd_d.xs    = ext_i ? xs_cnt_i : 3'd0;
    cmd_d.nargs = nargs;
    cmd_d.nstat = nstat;
    cmd_d.frame = frame;
  end

  sfs_slot_list i_slot_list (
    .ra_i       (cmd_q.ra),
    .s0_i       (cmd_q.s0),
    .s1_i       (cmd_q.s1),
    .xs_i       (cmd_q.xs),
    .nstat_i    (cmd_q.nstat),
    .slot_reg_o (slot_reg),
    .n_down_o   (n_down)
  );

  sfs_ctrl #(.AW(AW)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rsvd_i      (rsvd),
    .cmd_d_i     (cmd_d),
    .sp_i        (sp_i),
    .slot_reg_i  (slot_reg),
    .n_down_i    (n_down),
    .mem_ready_i (mem_ready_i),
    .cmd_q_o     (cmd_q),
    .mem_valid_o (mem_valid_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .reg_sel_o   (reg_sel),
    .rf_we_o     (rf_we_o),
    .sp_we_o     (sp_we_o),
    .sp_wdata_o  (sp_wdata_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  assign rf_raddr_o  = reg_sel;
  assign rf_waddr_o  = reg_sel;
  assign mem_wdata_o = rf_rdata_i;

  if (XLEN > WORD_W) begin : g_sext
    assign rf_wdata_o = {{(XLEN - WORD_W){mem_rdata_i[WORD_W-1]}}, mem_rdata_i};
  end else begin : g_same
    assign rf_wdata_o = mem_rdata_i[XLEN-1:0];
  end
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          rf_we_o,
  input logic          sp_we_o,
  input logic          done_o,
  input logic          err_o
);
  assert_hold_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_done_follows_sp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |=> done_o);

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_sp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(sp_we_o));

  assert_err_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!mem_valid_o && !sp_we_o && !done_o));

  assert_rf_write_on_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (mem_valid_o && mem_ready_i && !mem_we_o));

  assert_phase_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o, sp_we_o, mem_valid_o}));
endmodule

bind stack_frame_seq sfs_checker #(.AW(AW)) i_sfs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .rf_we_o     (rf_we_o),
  .sp_we_o     (sp_we_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_stack_frame_seq.sv
module test_stack_frame_seq;
  localparam int  AW      = 32;
  localparam int  XLEN    = 64;
  localparam time CLK_PER = 10ns;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0, save_i = 1'b0, ext_i = 1'b0;
  logic            ra_i = 1'b0, s0_i = 1'b0, s1_i = 1'b0;
  logic [2:0]      xs_cnt_i = '0;
  logic [3:0]      arg_code_i = '0, frame_hi_i = '0, frame_lo_i = '0;
  logic [AW-1:0]   sp_i = '0;
  logic            sp_we_o;
  logic [AW-1:0]   sp_wdata_o;
  logic            mem_valid_o, mem_ready_i = 1'b0, mem_we_o;
  logic [AW-1:0]   mem_addr_o;
  logic [31:0]     mem_wdata_o, mem_rdata_i;
  logic [4:0]      rf_raddr_o, rf_waddr_o;
  logic [31:0]     rf_rdata_i;
  logic            rf_we_o;
  logic [XLEN-1:0] rf_wdata_o;
  logic            done_o, err_o;

  int n_cmp = 0, n_bad = 0;
  bit summary_done = 0;

  always #(CLK_PER / 2) clk_i = ~clk_i;

  function automatic logic [31:0] rfval(input logic [4:0] r);
    return 32'hCAFE_0000 ^ (32'(r) << 9) ^ 32'(r);
  endfunction
  function automatic logic [31:0] memval(input logic [AW-1:0] a);
    return a ^ 32'h9E37_79B9;
  endfunction

  assign rf_rdata_i  = rfval(rf_raddr_o);
  assign mem_rdata_i = memval(mem_addr_o);

  stack_frame_seq #(.AW(AW), .XLEN(XLEN)) i_stack_frame_seq (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int b_nargs(input logic [3:0] c);
    case (c)
      4: return 1; 5: return 1; 6: return 1; 7: return 1;
      8: return 2; 9: return 2; 10: return 2;
      12: return 3; 13: return 3;
      14: return 4;
      default: return 0;
    endcase
  endfunction
  function automatic int b_nstat(input logic [3:0] c);
    case (c)
      1: return 1; 5: return 1; 9: return 1; 13: return 1;
      2: return 2; 6: return 2; 10: return 2;
      3: return 3; 7: return 3;
      11: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic run_cmd(input bit sv, input bit ex, input bit ra, input bit s0, input bit s1,
                         input logic [2:0] xs, input logic [3:0] code,
                         input logic [3:0] hi, input logic [3:0] lo, input logic [31:0] sp);
    int            ereg[20];
    logic [31:0]   eaddr[20];
    int            n_exp = 0, n_arg_acc = 0, got = 0, cyc = 0;
    int            xs_e, na, ns, frame;
    bit            rsvd, seen_err = 0, seen_sp = 0, prev_sp = 0, fin = 0, junk = 1;
    bit            stall_pend = 0;
    logic [31:0]   stall_addr = '0, ptr, exp_sp;
    int            xlist[7] = '{18, 19, 20, 21, 22, 23, 30};
    // expectation
    xs_e  = ex ? int'(xs) : 0;
    rsvd  = ex && code == 4'd15;
    na    = ex ? b_nargs(code) : 0;
    ns    = ex ? b_nstat(code) : 0;
    frame = ex ? int'({hi, lo}) * 8 : (lo == 0 ? 128 : int'(lo) * 8);
    if (sv) for (int k = 0; k < na; k++) begin
      ereg[n_exp] = 4 + k; eaddr[n_exp] = sp + 32'(4 * k); n_exp++; n_arg_acc++;
    end
    ptr = sv ? sp : sp + 32'(frame);
    if (ra) begin ptr -= 4; ereg[n_exp] = 31; eaddr[n_exp] = ptr; n_exp++; end
    for (int i = xs_e - 1; i >= 0; i--) begin ptr -= 4; ereg[n_exp] = xlist[i]; eaddr[n_exp] = ptr; n_exp++; end
    if (s1) begin ptr -= 4; ereg[n_exp] = 17; eaddr[n_exp] = ptr; n_exp++; end
    if (s0) begin ptr -= 4; ereg[n_exp] = 16; eaddr[n_exp] = ptr; n_exp++; end
    for (int j = 0; j < ns; j++) begin ptr -= 4; ereg[n_exp] = 7 - j; eaddr[n_exp] = ptr; n_exp++; end
    exp_sp = sv ? sp - 32'(frame) : sp + 32'(frame);
    if (rsvd) n_exp = 0;
    // launch
    @(negedge clk_i);
    start_i = 1; save_i = sv; ext_i = ex; ra_i = ra; s0_i = s0; s1_i = s1;
    xs_cnt_i = xs; arg_code_i = code; frame_hi_i = hi; frame_lo_i = lo; sp_i = sp;
    while (!fin) begin
      @(negedge clk_i);
      cyc++;
      if (junk) begin  // R12: junk command while busy
        start_i = 1; save_i = 1'($urandom); ext_i = 1'($urandom); ra_i = 1'($urandom);
        s0_i = 1'($urandom); s1_i = 1'($urandom); xs_cnt_i = 3'($urandom);
        arg_code_i = 4'($urandom); frame_hi_i = 4'($urandom); frame_lo_i = 4'($urandom);
        sp_i = $urandom;
      end
      mem_ready_i = ($urandom % 10) < 7;
      #1;
      if (stall_pend) begin
        check(mem_valid_o && mem_addr_o == stall_addr, "R9 held request", {31'd0, mem_valid_o, mem_addr_o}, {32'd1, stall_addr});
        stall_pend = 0;
      end
      if (done_o) begin
        check(prev_sp, "R10 done after sp write", 64'(done_o), 64'(prev_sp));
        fin = 1;
      end
      if (err_o) begin
        seen_err = 1; fin = 1; junk = 0; start_i = 0;
      end
      if (mem_valid_o && !mem_ready_i) begin stall_pend = 1; stall_addr = mem_addr_o; end
      if (mem_valid_o && mem_ready_i) begin
        if (got < n_exp) begin
          if (sv) begin
            check(mem_we_o && !rf_we_o && mem_addr_o == eaddr[got] && rf_raddr_o == 5'(ereg[got]) &&
                  mem_wdata_o == rfval(5'(ereg[got])),
                  got < n_arg_acc ? "R3 arg store" : "R4 save walk",
                  {mem_addr_o, mem_wdata_o}, {eaddr[got], rfval(5'(ereg[got]))});
          end else begin
            check(!mem_we_o && rf_we_o && mem_addr_o == eaddr[got] && rf_waddr_o == 5'(ereg[got]) &&
                  rf_wdata_o == {{32{memval(eaddr[got])[31]}}, memval(eaddr[got])},
                  "R7 R4 restore walk", {mem_addr_o, 27'd0, rf_waddr_o}, {eaddr[got], 32'(ereg[got])});
          end
        end
        got++;
      end
      if (sp_we_o) begin
        seen_sp = 1; junk = 0; start_i = 0;
        check(sp_wdata_o == exp_sp, sv ? "R8 R5 final sp" : "R7 R5 final sp", 64'(sp_wdata_o), 64'(exp_sp));
      end
      prev_sp = sp_we_o;
      if (cyc > 400) begin
        check(0, "timeout in command", 64'(cyc), 64'(0));
        fin = 1; junk = 0; start_i = 0;
      end
    end
    check(got == n_exp, ex ? "R1 R2 R4 R12 access count" : "R6 R4 R12 access count", 64'(got), 64'(n_exp));
    if (rsvd) check(seen_err && !seen_sp, "R11 reserved code", {62'd0, seen_err, seen_sp}, 64'd2);
    else      check(!seen_err && seen_sp, "R11 no error on valid code", {62'd0, seen_err, seen_sp}, 64'd1);
    start_i = 0; mem_ready_i = 0;
    @(negedge clk_i);
    #1;
    check(!done_o && !mem_valid_o && !err_o, "R10 idle after done", {61'd0, done_o, mem_valid_o, err_o}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(0, "watchdog", 64'd0, 64'd1);
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk_i);
    #1;
    check(!mem_valid_o && !done_o && !err_o && !sp_we_o && !rf_we_o, "reset outputs quiet",
          {59'd0, mem_valid_o, done_o, err_o, sp_we_o, rf_we_o}, 64'd0);
    rst_ni = 1'b1;
    // directed corners
    run_cmd(1, 1, 1, 1, 1, 3'd7, 4'd14, 4'hF, 4'hF, 32'h0000_0010); // R3 max args, wrap below zero
    run_cmd(0, 1, 1, 1, 1, 3'd7, 4'd11, 4'h2, 4'h1, 32'h0000_1000); // R2 four statics, restore
    run_cmd(1, 0, 1, 0, 1, 3'd5, 4'd9, 4'h7, 4'h0, 32'h0000_8000);  // R6 R5 short form 128
    run_cmd(1, 1, 0, 1, 0, 3'd2, 4'd15, 4'h1, 4'h1, 32'h0000_4000); // R11
    run_cmd(0, 1, 1, 0, 0, 3'd0, 4'd15, 4'h0, 4'h4, 32'h0000_4000); // R11 restore
    run_cmd(0, 0, 0, 0, 0, 3'd0, 4'd0, 4'h0, 4'h3, 32'hFFFF_FFF0);  // R7 empty walk, wrap up
    run_cmd(1, 1, 0, 0, 0, 3'd0, 4'd0, 4'h0, 4'h0, 32'h0000_2000);  // R5 zero frame
    run_cmd(0, 1, 0, 0, 1, 3'd1, 4'd7, 4'h3, 4'h3, 32'h0000_3000);  // R1 R2 code 7
    for (int c = 0; c < 16; c++)
      run_cmd(c[0], 1, 1, 1, 1, 3'(c), 4'(c), 4'h1, 4'(c), 32'h0001_0000); // R1 R2 every code
    for (int n = 0; n < 300; n++)
      run_cmd(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              3'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), $urandom & 32'hFFFF_FFFC);
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end
endmodule